// File: doc/BRIEF.md
# Keyed Configuration Write Lock

This block sits between a 32-bit memory-mapped bus and a peripheral register file. It guards a small group of critical configuration registers (the raster timing words, the two blanking words, the attribute word, the line-carry word and the key register itself). A write to one of these words reaches the register file only when the access just before it was a write of the key value 0xAA to the key register at byte offset 0x7C. Every other address passes its writes straight through at any time.

The gate is a two-state machine. `LOCKED` is entered at reset and after every bus access that is not a correct key write. `OPEN` is entered from either state by a correct key write. Idle cycles, with no bus access, leave the state alone. Forwarded writes and the rejected-write flag come out on registered outputs one clock after the access. Key writes are consumed by the gate and are never forwarded. The rejected flag lets a test see that a write was dropped.

Top module: `keyed_wr_lock`

## Requirements
- R1: After reset the block is in `LOCKED`, `cfg_we` and `wr_reject` are low, and the first protected write after reset is rejected.
- R2: A write of 0x000000AA to byte offset 0x7C moves the block to `OPEN`. The next access, if it is a protected write, is forwarded on `cfg_we`/`cfg_addr`/`cfg_wdata`.
- R3: The unlock covers exactly one access. After any access made in `OPEN` (other than another correct key write), the block is back in `LOCKED` and a further protected write is rejected.
- R4: Writes to unprotected offsets (for example 0x28, 0x54, 0x20, 0x230) are forwarded in either state. Such a write made in `OPEN` still consumes the unlock.
- R5: A protected write made in `LOCKED` is dropped: `cfg_we` stays low and `wr_reject` is high for exactly the one cycle belonging to that access.
- R6: A write of any value other than 0xAA to offset 0x7C is never forwarded, raises `wr_reject` and leaves the block in `LOCKED`. A correct key write raises neither `cfg_we` nor `wr_reject`.
- R7: A read access (`bus_vld` high, `bus_wr` low) forwards nothing but consumes an unlock.
- R8: The protected set is byte offsets 0x00 to 0x1C (word aligned), 0x24, 0x3C, 0x7C, 0x228 and 0x22C. Every other offset is unprotected.
- R9: A forwarded write or a rejection shows on the outputs on the first rising edge after the access cycle. `cfg_addr`/`cfg_wdata` carry the access's address and data.
- R10: Cycles with `bus_vld` low do not change the lock state, so an unlock survives any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | One bus access this cycle |
| bus_wr | input | 1 | Access is a write (low: read) |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| cfg_we | output | 1 | Write strobe to the register file |
| cfg_addr | output | 12 | Byte offset of the forwarded write |
| cfg_wdata | output | 32 | Data of the forwarded write |
| wr_reject | output | 1 | Pulse: protected write dropped |

## Verification
The assertions assume that each bus access lasts exactly one cycle with `bus_vld` high, and that `bus_wr`, `bus_addr` and `bus_wdata` are meaningful only in that cycle. The stimulus drives every access for a single clock and then either drives the next access or returns `bus_vld` low. It keeps addresses word aligned, so the two low address bits, which the decoder ignores, never distinguish two cases. Key writes, wrong keys, reads, idle gaps and unprotected writes are placed between unlocks so that each transition of the state machine is taken.

// File: rtl/keyed_wr_lock_pkg.sv
package keyed_wr_lock_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    localparam int NUM_SINGLES = 5;
endpackage

// File: rtl/klock_decode.sv
module klock_decode #(
    parameter int                   WADDR_W   = 10,
    parameter int                   TMR_WORDS = 8,
    parameter logic [WADDR_W-1:0]   KEY_WADDR = 10'h01F
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic               is_prot,
    output logic               is_key_reg
);
    import keyed_wr_lock_pkg::*;

    localparam logic [WADDR_W-1:0] SINGLES [NUM_SINGLES] = '{
        WADDR_W'(12'h024 >> 2),
        WADDR_W'(12'h03C >> 2),
        KEY_WADDR,
        WADDR_W'(12'h228 >> 2),
        WADDR_W'(12'h22C >> 2)
    };

    logic [NUM_SINGLES-1:0] single_hit;

    for (genvar g = 0; g < NUM_SINGLES; g++) begin : g_single
        assign single_hit[g] = (waddr == SINGLES[g]);
    end

    always_comb begin
        is_key_reg = (waddr == KEY_WADDR);
        is_prot    = (waddr < WADDR_W'(TMR_WORDS)) || (|single_hit);
    end
endmodule

// File: rtl/klock_fsm.sv
module klock_fsm (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           acc_vld,
    input  logic                           key_hit,
    output keyed_wr_lock_pkg::lock_state_e state_q,
    output logic                           is_open
);
    import keyed_wr_lock_pkg::*;

    lock_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOCKED;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (acc_vld && key_hit)  state_d = ST_OPEN;
            ST_OPEN:   if (acc_vld && !key_hit) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        is_open = (state_q == ST_OPEN);
    end
endmodule

// File: rtl/klock_gate.sv
module klock_gate #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              is_prot,
    input  logic              is_key_reg,
    input  logic              key_ok,
    input  logic              is_open,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              wr_reject
);
    logic pass_d;
    logic drop_d;

    always_comb begin
        pass_d = 1'b0;
        drop_d = 1'b0;
        if (wr_vld) begin
            if (is_key_reg)   drop_d = !key_ok;
            else if (!is_prot) pass_d = 1'b1;
            else if (is_open)  pass_d = 1'b1;
            else               drop_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_we    <= 1'b0;
            wr_reject <= 1'b0;
            cfg_addr  <= '0;
            cfg_wdata <= '0;
        end else begin
            cfg_we    <= pass_d;
            wr_reject <= drop_d;
            if (pass_d) begin
                cfg_addr  <= addr;
                cfg_wdata <= wdata;
            end
        end
    end
endmodule

// File: rtl/keyed_wr_lock.sv
module keyed_wr_lock #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h07C,
    parameter logic [DATA_W-1:0] KEY_VALUE = 32'h0000_00AA,
    parameter int                TMR_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              wr_reject
);
    import keyed_wr_lock_pkg::*;

    localparam int WADDR_W = ADDR_W - 2;

    logic        is_prot;
    logic        is_key_reg;
    logic        key_ok;
    logic        key_hit;
    logic        wr_vld;
    logic        is_open;
    lock_state_e lk_state;

    klock_decode #(
        .WADDR_W  (WADDR_W),
        .TMR_WORDS(TMR_WORDS),
        .KEY_WADDR(KEY_ADDR[ADDR_W-1:2])
    ) u_decode (
        .waddr     (bus_addr[ADDR_W-1:2]),
        .is_prot   (is_prot),
        .is_key_reg(is_key_reg)
    );

    assign wr_vld  = bus_vld && bus_wr;
    assign key_ok  = (bus_wdata == KEY_VALUE);
    assign key_hit = wr_vld && is_key_reg && key_ok;

    klock_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .acc_vld(bus_vld),
        .key_hit(key_hit),
        .state_q(lk_state),
        .is_open(is_open)
    );

    klock_gate #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .wr_vld    (wr_vld),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .is_prot   (is_prot),
        .is_key_reg(is_key_reg),
        .key_ok    (key_ok),
        .is_open   (is_open),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .wr_reject (wr_reject)
    );
endmodule

// File: rtl/keyed_wr_lock_chk.sv
module keyed_wr_lock_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h07C,
    parameter logic [DATA_W-1:0] KEY_VALUE = 32'h0000_00AA
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_vld,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic                           cfg_we,
    input logic                           wr_reject,
    input keyed_wr_lock_pkg::lock_state_e lk_state
);
    import keyed_wr_lock_pkg::*;

    logic key_wr;
    assign key_wr = bus_vld && bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata == KEY_VALUE);

    AST_WE_XOR_REJECT: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && wr_reject)); // R5

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        key_wr |=> (lk_state == ST_OPEN)); // R2

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (lk_state == ST_OPEN && bus_vld && !key_wr) |=> (lk_state == ST_LOCKED)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_vld |=> $stable(lk_state)); // R10

    AST_FREE_PASS: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && bus_wr && bus_addr == 12'h054) |=> (cfg_we && !wr_reject)); // R4

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (rst)
        (lk_state == ST_LOCKED && bus_vld && bus_wr && bus_addr == 12'h000)
        |=> (!cfg_we && wr_reject)); // R5

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && bus_wr && bus_addr == KEY_ADDR && bus_wdata != KEY_VALUE)
        |=> (lk_state == ST_LOCKED && wr_reject)); // R6

    AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && !bus_wr) |=> (lk_state == ST_LOCKED && !cfg_we && !wr_reject)); // R7
endmodule

bind keyed_wr_lock keyed_wr_lock_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_ADDR (KEY_ADDR),
    .KEY_VALUE(KEY_VALUE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_vld  (bus_vld),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cfg_we   (cfg_we),
    .wr_reject(wr_reject),
    .lk_state (lk_state)
);

// File: tb/keyed_wr_lock_tb_top.sv
module keyed_wr_lock_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        cfg_we;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        wr_reject;

    typedef struct {
        logic        we;
        logic        rej;
        logic [11:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   model_open = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    keyed_wr_lock dut_i (
        .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .wr_reject(wr_reject)
    );

    // protected set as listed in R8
    function automatic bit prot(input logic [11:0] a);
        return (a <= 12'h01C) || a == 12'h024 || a == 12'h03C || a == 12'h07C
            || a == 12'h228 || a == 12'h22C;
    endfunction

    task automatic push(input logic we, input logic rej, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        exp_t e;
        e.we = we; e.rej = rej; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 12'h07C) begin
            push(1'b0, d != 32'hAA, a, d, tag);
            model_open = (d == 32'hAA);
        end else if (!prot(a) || model_open) begin
            push(1'b1, 1'b0, a, d, tag);
            model_open = 1'b0;
        end else begin
            push(1'b0, 1'b1, a, d, tag);
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
        push(1'b0, 1'b0, a, 32'h0, tag);
        model_open = 1'b0;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
        push(1'b0, 1'b0, 12'h0, 32'h0, tag);
    endtask

    // monitor: result of the access driven at a negedge appears after the next posedge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (cfg_we !== e.we || wr_reject !== e.rej ||
                    (e.we && (cfg_addr !== e.addr || cfg_wdata !== e.data))) begin
                    bad++;
                    $display("FAIL %s: we=%0b rej=%0b addr=%h data=%h exp we=%0b rej=%0b addr=%h data=%h",
                             e.tag, cfg_we, wr_reject, cfg_addr, cfg_wdata,
                             e.we, e.rej, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (cfg_we !== 1'b0 || wr_reject !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset outputs: we=%0b rej=%0b exp 0 0", cfg_we, wr_reject);
        end
        rst = 1'b0;

        wr(12'h000, 32'h0000_0111, "R1 locked after reset");
        wr(12'h07C, 32'h0000_00AA, "R6 key accepted silently");
        wr(12'h004, 32'h0000_0222, "R2 R9 unlocked write forwarded");
        wr(12'h008, 32'h0000_0333, "R3 second write rejected");
        idle("R5 reject lasts one cycle");
        wr(12'h054, 32'h0000_0444, "R4 pixel-mode locked");
        wr(12'h028, 32'h0000_0555, "R4 screen base locked");
        wr(12'h07C, 32'h0000_00AB, "R6 wrong key");
        wr(12'h024, 32'h0000_0666, "R6 still locked");
        wr(12'h07C, 32'h0000_00AA, "R10 key");
        idle("R10 idle 1");
        idle("R10 idle 2");
        idle("R10 idle 3");
        wr(12'h22C, 32'h0000_0777, "R10 R8 unlock survives idle");
        wr(12'h07C, 32'h0000_00AA, "R7 key");
        rd(12'h03C, "R7 read");
        wr(12'h03C, 32'h0000_0888, "R7 read consumed unlock");
        wr(12'h07C, 32'h0000_00AA, "R4 key");
        wr(12'h054, 32'h0000_0999, "R4 unprotected in open");
        wr(12'h01C, 32'h0000_0AAA, "R4 unprotected consumed unlock");
        wr(12'h07C, 32'h0000_00AA, "R2 key twice a");
        wr(12'h07C, 32'h0000_00AA, "R2 key twice b");
        wr(12'h228, 32'h0000_0BBB, "R2 R8 open after repeated key");
        wr(12'h020, 32'h0000_0CCC, "R8 0x20 unprotected");
        wr(12'h230, 32'h0000_0DDD, "R8 0x230 unprotected");
        wr(12'h018, 32'h0000_0EEE, "R8 timing top rejected");
        wr(12'h03C, 32'h0000_0FFF, "R8 line carry rejected");
        wr(12'h07C, 32'h0000_00AA, "R8 key");
        wr(12'h024, 32'h1234_5678, "R8 R9 attribute forwarded");
        wr(12'h07C, 32'h0000_00AA, "R6 key then wrong key");
        wr(12'h07C, 32'h0000_0000, "R6 wrong key while open");
        wr(12'h000, 32'h0000_1111, "R6 relocked by wrong key");
        idle("R5 final idle");
        idle("R5 final idle 2");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, exp completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule